// File: doc/BRIEF.md
# Reset Cause Capture Register

This block gathers every reset request of a small controller into one stretched system reset and keeps an 8-bit control and status register that tells software what caused the most recent reset. The requests are a power-on event, a supply monitor trip, an external reset pin, a watchdog timeout, a missing clock detector, an active-low comparator, a USB bus reset, a flash access error and a software request. The detectors themselves live elsewhere and arrive here as plain request inputs that are already synchronous to `clk`.

Several register bits have two meanings. A normal read returns the latched cause flag. A write sets the enable of an optional reset source. A read that is flagged as the first half of a read-modify-write returns the stored enable instead, so that writing the value back keeps the enables and does not disturb the flags. The power-on input is an asynchronous active-low reset that initialises everything. All other resets leave the enables untouched.

Top module: `rst_cause_ctl`

## Requirements
- R1: After any reset exactly one cause flag is set. The bit positions are: 0 external pin, 1 power-on or supply monitor, 2 missing clock, 3 watchdog, 4 software, 5 comparator, 6 flash error, 7 USB.
- R2: While `por_n` is low, the flags become 0x02, the USB, comparator and missing clock enables clear, and the supply monitor enable sets. `sys_rst` stays high for 16 cycles after `por_n` rises.
- R3: With `rd_en` high and `rmw` low, `rdata` is the flag byte. With `rmw` high, bits 7, 5, 2 and 1 return the USB, comparator, missing clock and supply monitor enables, bit 4 returns 0, and bits 6, 3 and 0 return their flags.
- R4: A write while `sys_rst` is low loads the enables from `wdata` bits 7, 5, 2 and 1. Bits 6, 3 and 0 of a write change nothing. A write while `sys_rst` is high is ignored completely.
- R5: Writing 1 to bit 4 forces a reset, and bit 4 is then the flag that reads 1. Writing 0 to bit 4 causes no reset.
- R6: The comparator request `req_cmp_n` is active low. It causes a reset only while the comparator enable is 1.
- R7: `req_clkloss` causes a reset only while the missing clock enable is 1. `req_usb` causes a reset only while the USB enable is 1.
- R8: `req_supply` causes a reset only while the supply monitor enable is 1 and `mon_ready` is high. Such a reset sets flag bit 1 and keeps all enables.
- R9: When several requests are accepted in the same cycle, one flag is recorded, by the priority pin, supply, missing clock, watchdog, software, comparator, USB, flash error.
- R10: `sys_rst` rises on the clock edge that samples an accepted request. It stays high until 16 edges after the last edge that sampled one. A request that arrives while `sys_rst` is high extends the reset but does not change the flags.
- R11: While `rd_en` is low, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| req_pin | input | 1 | External reset pin request, active high |
| req_supply | input | 1 | Supply monitor trip request |
| mon_ready | input | 1 | Supply monitor has settled |
| req_clkloss | input | 1 | Missing clock detector request |
| req_wdog | input | 1 | Watchdog timeout request |
| req_cmp_n | input | 1 | Comparator request, active low |
| req_usb | input | 1 | USB bus reset request |
| req_flash | input | 1 | Flash access error request |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| rmw | input | 1 | Current read belongs to a read-modify-write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| sys_rst | output | 1 | Stretched system reset, active high |

## Verification
The bench drives the gated sources with their enables off and then on. A design that ignored an enable would reset where none is due, and one that read the comparator with the wrong polarity would reset while the comparator is idle. It makes simultaneous requests and late requests arriving during the stretch. A wrong priority order or a flag overwritten during reset would then show a different cause bit. It also compares the read-modify-write view against the plain view after enables have survived a watchdog reset, and measures the length of the stretch for a request held several cycles. An off-by-one counter, a lost enable, or a software bit that reads back as 1 in the read-modify-write view would each give a wrong byte or a wrong cycle count.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int REG_W   = 8;
  localparam int B_PIN   = 0;
  localparam int B_PWR   = 1;
  localparam int B_MCD   = 2;
  localparam int B_WDT   = 3;
  localparam int B_SW    = 4;
  localparam int B_CMP   = 5;
  localparam int B_FLASH = 6;
  localparam int B_USB   = 7;

  // rank 0 is the highest priority
  function automatic int prio_bit(input int rank);
    case (rank)
      0:       prio_bit = B_PIN;
      1:       prio_bit = B_PWR;
      2:       prio_bit = B_MCD;
      3:       prio_bit = B_WDT;
      4:       prio_bit = B_SW;
      5:       prio_bit = B_CMP;
      6:       prio_bit = B_USB;
      default: prio_bit = B_FLASH;
    endcase
  endfunction

  function automatic logic [REG_W-1:0] pick_cause(input logic [REG_W-1:0] act);
    logic [REG_W-1:0] r;
    r = '0;
    for (int k = REG_W - 1; k >= 0; k--)
      if (act[prio_bit(k)]) r = REG_W'(1) << prio_bit(k);
    return r;
  endfunction

  function automatic logic [REG_W-1:0] rmw_view(input logic [REG_W-1:0] flags,
                                                input logic e_usb, input logic e_cmp,
                                                input logic e_mcd, input logic e_vmon);
    logic [REG_W-1:0] v;
    v        = flags;
    v[B_USB] = e_usb;
    v[B_CMP] = e_cmp;
    v[B_SW]  = 1'b0;
    v[B_MCD] = e_mcd;
    v[B_PWR] = e_vmon;
    return v;
  endfunction
endpackage

// File: rtl/rcc_req_gate.sv
module rcc_req_gate
  import rcc_pkg::*;
(
  input  logic             req_pin,
  input  logic             req_supply,
  input  logic             mon_ready,
  input  logic             req_clkloss,
  input  logic             req_wdog,
  input  logic             req_cmp_n,
  input  logic             req_usb,
  input  logic             req_flash,
  input  logic             sw_req,
  input  logic             en_usb,
  input  logic             en_cmp,
  input  logic             en_mcd,
  input  logic             en_vmon,
  output logic [REG_W-1:0] act
);
  always_comb begin
    act          = '0;
    act[B_PIN]   = req_pin;
    act[B_PWR]   = req_supply & mon_ready & en_vmon;
    act[B_MCD]   = req_clkloss & en_mcd;
    act[B_WDT]   = req_wdog;
    act[B_SW]    = sw_req;
    act[B_CMP]   = ~req_cmp_n & en_cmp;
    act[B_FLASH] = req_flash;
    act[B_USB]   = req_usb & en_usb;
  end
endmodule

// File: rtl/rcc_stretch.sv
module rcc_stretch #(
  parameter int STRETCH_CYC = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic any_act,
  output logic sys_rst
);
  localparam int CNT_W = $clog2(STRETCH_CYC + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(STRETCH_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              cnt <= LOAD;
    else if (any_act)        cnt <= LOAD;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign sys_rst = (cnt != '0);
endmodule

// File: rtl/rcc_csr.sv
module rcc_csr
  import rcc_pkg::*;
(
  input  logic             clk,
  input  logic             por_n,
  input  logic             in_rst,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic             rmw,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] act,
  output logic [REG_W-1:0] rdata,
  output logic [REG_W-1:0] flags,
  output logic             en_usb,
  output logic             en_cmp,
  output logic             en_mcd,
  output logic             en_vmon,
  output logic             wr_ok,
  output logic             sw_req,
  output logic             take_cause
);
  assign wr_ok      = wr_en & ~in_rst;
  assign sw_req     = wr_ok & wdata[B_SW];
  assign take_cause = (|act) & ~in_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flags   <= REG_W'(1) << B_PWR;
      en_usb  <= 1'b0;
      en_cmp  <= 1'b0;
      en_mcd  <= 1'b0;
      en_vmon <= 1'b1;
    end else begin
      if (take_cause) flags <= pick_cause(act);
      if (wr_ok) begin
        en_usb  <= wdata[B_USB];
        en_cmp  <= wdata[B_CMP];
        en_mcd  <= wdata[B_MCD];
        en_vmon <= wdata[B_PWR];
      end
    end
  end

  always_comb begin
    if (!rd_en)   rdata = '0;
    else if (rmw) rdata = rmw_view(flags, en_usb, en_cmp, en_mcd, en_vmon);
    else          rdata = flags;
  end
endmodule

// File: rtl/rst_cause_ctl.sv
module rst_cause_ctl
  import rcc_pkg::*;
#(
  parameter int STRETCH_CYC = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             req_pin,
  input  logic             req_supply,
  input  logic             mon_ready,
  input  logic             req_clkloss,
  input  logic             req_wdog,
  input  logic             req_cmp_n,
  input  logic             req_usb,
  input  logic             req_flash,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic             rmw,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  output logic             sys_rst
);
  logic [REG_W-1:0] act_vec;
  logic [REG_W-1:0] cause_flags;
  logic             any_act;
  logic             take_cause;
  logic             wr_ok;
  logic             sw_req;
  logic             en_usb, en_cmp, en_mcd, en_vmon;
  logic [3:0]       en_vec;

  assign any_act = |act_vec;
  assign en_vec  = {en_usb, en_cmp, en_mcd, en_vmon};

  rcc_req_gate u_gate (
    .req_pin(req_pin), .req_supply(req_supply), .mon_ready(mon_ready),
    .req_clkloss(req_clkloss), .req_wdog(req_wdog), .req_cmp_n(req_cmp_n),
    .req_usb(req_usb), .req_flash(req_flash), .sw_req(sw_req),
    .en_usb(en_usb), .en_cmp(en_cmp), .en_mcd(en_mcd), .en_vmon(en_vmon),
    .act(act_vec)
  );

  rcc_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
    .clk(clk), .por_n(por_n), .any_act(any_act), .sys_rst(sys_rst)
  );

  rcc_csr u_csr (
    .clk(clk), .por_n(por_n), .in_rst(sys_rst), .rd_en(rd_en), .wr_en(wr_en),
    .rmw(rmw), .wdata(wdata), .act(act_vec), .rdata(rdata), .flags(cause_flags),
    .en_usb(en_usb), .en_cmp(en_cmp), .en_mcd(en_mcd), .en_vmon(en_vmon),
    .wr_ok(wr_ok), .sw_req(sw_req), .take_cause(take_cause)
  );
endmodule

// File: rtl/rcc_chk.sv
module rcc_chk
  import rcc_pkg::*;
(
  input logic             clk,
  input logic             por_n,
  input logic             rd_en,
  input logic             req_cmp_n,
  input logic [REG_W-1:0] rdata,
  input logic             sys_rst,
  input logic [REG_W-1:0] act_vec,
  input logic [REG_W-1:0] cause_flags,
  input logic             any_act,
  input logic             take_cause,
  input logic             wr_ok,
  input logic [3:0]       en_vec
);
  a_r1_single_flag: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause_flags) == 1);

  a_r10_cause_starts_rst: assert property (@(posedge clk) disable iff (!por_n)
    take_cause |=> sys_rst);

  a_r10_request_holds_rst: assert property (@(posedge clk) disable iff (!por_n)
    any_act |=> sys_rst);

  a_r10_release_after_quiet: assert property (@(posedge clk) disable iff (!por_n)
    $fell(sys_rst) |-> !$past(any_act));

  a_r10_flags_only_on_cause: assert property (@(posedge clk) disable iff (!por_n)
    !take_cause |=> $stable(cause_flags));

  a_r4_enables_only_on_write: assert property (@(posedge clk) disable iff (!por_n)
    !wr_ok |=> $stable(en_vec));

  a_r4_no_write_in_rst: assert property (@(posedge clk) disable iff (!por_n)
    sys_rst |-> !wr_ok);

  a_r6_cmp_idle_high: assert property (@(posedge clk) disable iff (!por_n)
    req_cmp_n |-> !act_vec[B_CMP]);

  a_r11_quiet_bus: assert property (@(posedge clk) disable iff (!por_n)
    !rd_en |-> rdata == '0);
endmodule

bind rst_cause_ctl rcc_chk u_chk (
  .clk(clk), .por_n(por_n), .rd_en(rd_en), .req_cmp_n(req_cmp_n), .rdata(rdata),
  .sys_rst(sys_rst), .act_vec(act_vec), .cause_flags(cause_flags), .any_act(any_act),
  .take_cause(take_cause), .wr_ok(wr_ok), .en_vec(en_vec)
);

// File: tb/rst_cause_ctl_test.sv
`timescale 1ns/1ps
module rst_cause_ctl_test;
  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic req_pin = 0, req_supply = 0, mon_ready = 1, req_clkloss = 0, req_wdog = 0;
  logic req_cmp_n = 1, req_usb = 0, req_flash = 0;
  logic rd_en = 0, wr_en = 0, rmw = 0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sys_rst;

  int n_checks = 0;
  int n_errs = 0;
  bit run = 0;

  always #10 clk = ~clk;

  rst_cause_ctl uut (
    .clk(clk), .por_n(por_n), .req_pin(req_pin), .req_supply(req_supply),
    .mon_ready(mon_ready), .req_clkloss(req_clkloss), .req_wdog(req_wdog),
    .req_cmp_n(req_cmp_n), .req_usb(req_usb), .req_flash(req_flash),
    .rd_en(rd_en), .wr_en(wr_en), .rmw(rmw), .wdata(wdata),
    .rdata(rdata), .sys_rst(sys_rst)
  );

  // behavioural reference model
  int       m_cnt;
  bit [7:0] m_flg;
  bit       m_usb, m_cmp, m_mcd, m_vm;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_flg = 8'h02; m_usb = 0; m_cmp = 0; m_mcd = 0; m_vm = 1; m_cnt = 16;
    end else begin
      bit busy, wr, p_pin, p_sup, p_mcd, p_wdt, p_sw, p_cmp, p_usb, p_fl;
      busy  = (m_cnt > 0);
      wr    = wr_en && !busy;
      p_pin = req_pin;
      p_sup = req_supply && mon_ready && m_vm;
      p_mcd = req_clkloss && m_mcd;
      p_wdt = req_wdog;
      p_sw  = wr && wdata[4];
      p_cmp = !req_cmp_n && m_cmp;
      p_usb = req_usb && m_usb;
      p_fl  = req_flash;
      if (!busy) begin
        if (p_pin)      m_flg = 8'h01;
        else if (p_sup) m_flg = 8'h02;
        else if (p_mcd) m_flg = 8'h04;
        else if (p_wdt) m_flg = 8'h08;
        else if (p_sw)  m_flg = 8'h10;
        else if (p_cmp) m_flg = 8'h20;
        else if (p_usb) m_flg = 8'h80;
        else if (p_fl)  m_flg = 8'h40;
      end
      if (wr) begin
        m_usb = wdata[7]; m_cmp = wdata[5]; m_mcd = wdata[2]; m_vm = wdata[1];
      end
      if (p_pin || p_sup || p_mcd || p_wdt || p_sw || p_cmp || p_usb || p_fl) m_cnt = 16;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
    end
  end

  function automatic bit [7:0] model_rd();
    if (!rd_en) return 8'h00;
    if (rmw) return {m_usb, m_flg[6], m_cmp, 1'b0, m_flg[3], m_mcd, m_vm, m_flg[0]};
    return m_flg;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always begin
    @(negedge clk);
    #5;
    if (run && por_n) begin
      check("R10 sys_rst vs model", {7'b0, sys_rst}, {7'b0, (m_cnt > 0)});
      check("R3 rdata vs model", rdata, model_rd());
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    while (sys_rst) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wdata = d;
    @(negedge clk); wr_en = 0; wdata = 8'h00;
  endtask

  task automatic rd(input bit m, input logic [7:0] exp, input string tag);
    @(negedge clk); rd_en = 1; rmw = m;
    #5 check(tag, rdata, exp);
    @(negedge clk); rd_en = 0; rmw = 0;
  endtask

  task automatic no_rst_for(input int n, input string tag);
    bit seen = 0;
    repeat (n) begin @(negedge clk); #5 if (sys_rst) seen = 1; end
    check(tag, {7'b0, seen}, 8'h00);
  endtask

  initial begin
    #(20 * 100000);
    n_errs++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end

  initial begin
    run = 1;
    idle(3);
    #5 check("R2 sys_rst held during por", {7'b0, sys_rst}, 8'h01);
    por_n = 1;
    settle();
    rd(0, 8'h02, "R2 flags after power-on");
    rd(1, 8'h02, "R2 R3 rmw view after power-on");
    #5 check("R11 rdata idle", rdata, 8'h00);

    // enables, software bit written 0
    wr(8'hEF);
    no_rst_for(4, "R5 bit4 written 0 gives no reset");
    rd(1, 8'hA6, "R4 R3 enables loaded");
    rd(0, 8'h02, "R4 flags unchanged by write");

    // watchdog, enables survive
    @(negedge clk); req_wdog = 1; @(negedge clk); req_wdog = 0;
    settle();
    rd(0, 8'h08, "R1 watchdog flag");
    rd(1, 8'hAE, "R3 rmw view keeps enables");

    // software reset
    wr(8'h10);
    settle();
    rd(0, 8'h10, "R5 software flag");
    rd(1, 8'h00, "R5 R3 rmw bit4 reads 0");

    // comparator
    @(negedge clk); req_cmp_n = 0;
    no_rst_for(4, "R6 comparator disabled");
    req_cmp_n = 1;
    wr(8'h20);
    @(negedge clk); req_cmp_n = 0; idle(2); req_cmp_n = 1;
    settle();
    rd(0, 8'h20, "R6 comparator flag");

    // clock loss and usb gating, then priority
    @(negedge clk); req_clkloss = 1; req_usb = 1;
    no_rst_for(3, "R7 clkloss and usb disabled");
    req_clkloss = 0; req_usb = 0;
    wr(8'h84);
    @(negedge clk); req_clkloss = 1; req_usb = 1; @(negedge clk); req_clkloss = 0; req_usb = 0;
    settle();
    rd(0, 8'h04, "R9 R7 clkloss over usb");
    @(negedge clk); req_usb = 1; @(negedge clk); req_usb = 0;
    settle();
    rd(0, 8'h80, "R7 usb flag");

    // supply monitor
    @(negedge clk); req_supply = 1;
    no_rst_for(3, "R8 supply monitor disabled");
    req_supply = 0;
    wr(8'h86);
    @(negedge clk); mon_ready = 0; req_supply = 1;
    no_rst_for(3, "R8 monitor not ready");
    req_supply = 0; mon_ready = 1;
    @(negedge clk); req_supply = 1; @(negedge clk); req_supply = 0;
    settle();
    rd(0, 8'h02, "R8 supply flag");
    rd(1, 8'h86, "R8 enables survive supply reset");

    // priority and read-only bits
    @(negedge clk); req_pin = 1; req_flash = 1; req_wdog = 1;
    @(negedge clk); req_pin = 0; req_flash = 0; req_wdog = 0;
    settle();
    rd(0, 8'h01, "R9 pin wins");
    @(negedge clk); req_flash = 1; @(negedge clk); req_flash = 0;
    settle();
    rd(0, 8'h40, "R9 flash flag");
    wr(8'h49);
    rd(0, 8'h40, "R4 read-only bits ignore write");
    rd(1, 8'h40, "R4 enables cleared by write");

    // stretch length for a 3-cycle request
    begin
      int hi = 0;
      @(negedge clk); req_wdog = 1;
      for (int i = 0; i < 30; i++) begin
        if (i == 3) req_wdog = 0;
        #5 if (sys_rst) hi++;
        @(negedge clk);
      end
      check("R10 stretch cycles", 8'(hi), 8'd18);
    end

    // late request and write during reset
    @(negedge clk); req_wdog = 1; @(negedge clk); req_wdog = 0;
    idle(2); req_pin = 1; wr_en = 1; wdata = 8'hFF;
    @(negedge clk); req_pin = 0; wr_en = 0; wdata = 8'h00;
    settle();
    rd(0, 8'h08, "R10 late request keeps flag");
    rd(1, 8'h08, "R4 write in reset ignored");

    // power-on again
    @(negedge clk); por_n = 0; idle(2); por_n = 1;
    settle();
    rd(0, 8'h02, "R2 second power-on flags");
    rd(1, 8'h02, "R2 second power-on enables");

    idle(2);
    run = 0;
    $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    $finish;
  end
endmodule